// File: doc/BRIEF.md
# Piecewise-Linear Tone Curve Evaluator

This block approximates a nonlinear tone curve, such as a luminance correction or a reflectance boost, with straight-line segments. A small shape index picks one curve out of a family. Each sample is first compared in parallel against a set of fixed segment boundaries. The boundaries are spaced unevenly: by default they follow a cubic progression that packs them tightly near zero. An exponential progression can be chosen instead.

The segment number and the shape index together select one slope and one offset from a coefficient store. A single multiplier and adder then form `slope * sample + offset`. The result is clamped to the output range rather than wrapping.

The coefficient store is loaded once at start-up through a plain write port. After that, samples stream through at one per clock with a fixed two-cycle delay. Samples, slopes and offsets are two's-complement fixed point with 6 fraction bits. With the default 8 integer bits a value is 15 bits wide. The boundary constants keep only 2 fraction bits.

Top module: `pwl_curve_eval`

## Requirements
- R1: Boundary k (k = 0 .. NUM_SEG-1) is a constant in quarter units.
  - With the cubic law (the default) its value is floor(2^(INT_W+2) * k^3 / NUM_SEG^3).
  - With the exponential law its value is 2^(INT_W+2) >> (NUM_SEG-k).
  - The defaults give 0, 0, 2, 6, 16, 31, 54, 85, 128, 182, 250, 332, 432, 549, 686, 843.
- R2: The sample is compared against every boundary times 16 (the boundary scaled to 6 fraction bits). The segment is the count of boundaries at or below the sample, minus one, and is never below 0.
  - A sample below the first boundary uses segment 0.
  - A sample at or above the last boundary uses segment NUM_SEG-1.
- R3: A write with `cfg_we` high stores `cfg_slope` and `cfg_offset` at entry (`cfg_seg`, `cfg_shape`). A later write to the same entry replaces it.
- R4: The output value is floor((slope*sample + offset*64) / 64). Slope, sample and offset are all read as signed values with 6 fraction bits, and the division floors toward minus infinity.
- R5: A result above 2^(DATA_W-1)-1 is output as 2^(DATA_W-1)-1. A result below -2^(DATA_W-1) is output as -2^(DATA_W-1).
- R6: `res_valid` is high exactly two rising edges after the edge that sampled `smp_valid` high, and low otherwise.
- R7: While no valid result is produced, `res_sample` keeps its last value.
- R8: During synchronous active-low reset, `res_valid` and `res_sample` go to 0. Coefficients are not cleared.
- R9: The shape index sampled with a sample selects which coefficient pair is used. The same sample with different shapes yields the curve of each shape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | DATA_W | Signed input sample, 6 fraction bits |
| smp_shape | input | SHAPE_W | Curve shape index |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_seg | input | SEG_W | Segment of the entry written |
| cfg_shape | input | SHAPE_W | Shape of the entry written |
| cfg_slope | input | COEF_W | Signed slope, 6 fraction bits |
| cfg_offset | input | DATA_W | Signed offset, 6 fraction bits |
| res_valid | output | 1 | Result qualifier |
| res_sample | output | DATA_W | Saturated signed result, 6 fraction bits |

## Verification
Random samples with random shape indices stream back to back through a table of random small slopes and offsets. Mismatches in segment choice or coefficient addressing show up as wrong values in that stream.

Directed samples sit exactly on each distinct boundary and one least-significant step below it. These separate a `>=` comparison from a `>`, and off-by-one segment numbering. The extreme positive and negative samples exercise the clamped first and last segments.

Further directed cases check the following:
- Rewritten entries with very large slopes drive the result past both rails, which tells saturation apart from wrap-around.
- A slope of minus one LSB on a one-LSB sample tells floor rounding apart from truncation.
- Idle gaps show whether the output holds its value between results.

// File: rtl/pwl_pkg.sv
// Package: shared constants and the boundary law for the curve evaluator.
// Assumes boundaries are nondecreasing in k for either law.
package pwl_pkg;

    localparam int EDGE_FRAC = 2;

    // Boundary k in quarter units, for a span of 2^(int_w) integer values.
    function automatic longint edge_quarters(input int k, input int nseg,
                                             input int int_w, input bit exp_law);
        longint span;
        span = longint'(1) << (int_w + EDGE_FRAC);
        if (exp_law)
            return span >> (nseg - k);
        return (span * k * k * k) / (longint'(nseg) * nseg * nseg);
    endfunction

endpackage

// File: rtl/pwl_seg_finder.sv
// Segment finder: compares the sample against all boundaries at once and
// turns the thermometer result into a segment number.
// Assumes boundaries are nondecreasing, so the compare vector is a thermometer.
module pwl_seg_finder #(
    parameter int  NUM_SEG = 16,
    parameter int  INT_W   = 8,
    parameter int  FRAC_W  = 6,
    parameter bit  EXP_LAW = 1'b0,
    localparam int DATA_W  = 1 + INT_W + FRAC_W,
    localparam int SEG_W   = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic signed [DATA_W-1:0] x,
    output logic        [NUM_SEG-1:0] ge,
    output logic        [SEG_W-1:0]   seg
);
    localparam int CMP_W = DATA_W + 2;
    localparam int SHIFT = FRAC_W - pwl_pkg::EDGE_FRAC;

    logic signed [CMP_W-1:0] x_ext;
    logic        [SEG_W:0]   cnt;

    assign x_ext = CMP_W'(x);

    // One comparator per boundary, each against its own constant.
    for (genvar k = 0; k < NUM_SEG; k++) begin : g_cmp
        localparam logic signed [CMP_W-1:0] EDGE =
            CMP_W'(pwl_pkg::edge_quarters(k, NUM_SEG, INT_W, EXP_LAW) << SHIFT);
        assign ge[k] = (x_ext >= EDGE);
    end

    // Count boundaries at or below the sample.
    always_comb begin
        cnt = '0;
        for (int k = 0; k < NUM_SEG; k++)
            cnt = cnt + (SEG_W+1)'(ge[k]);
    end

    // Segment is the count minus one, never below zero.
    always_comb begin
        if (cnt == '0)
            seg = '0;
        else
            seg = SEG_W'(cnt - 1'b1);
    end

endmodule

// File: rtl/pwl_coef_table.sv
// Coefficient store: one slope/offset pair per (segment, shape).
// Written at start-up; read once per valid sample into a register.
// Assumes NUM_SHAPE and NUM_SEG fill their index widths.
module pwl_coef_table #(
    parameter int  NUM_SEG   = 16,
    parameter int  NUM_SHAPE = 4,
    parameter int  DATA_W    = 15,
    parameter int  COEF_W    = 15,
    localparam int SEG_W     = (NUM_SEG > 1)   ? $clog2(NUM_SEG)   : 1,
    localparam int SHAPE_W   = (NUM_SHAPE > 1) ? $clog2(NUM_SHAPE) : 1
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [SEG_W-1:0]         wr_seg,
    input  logic [SHAPE_W-1:0]       wr_shape,
    input  logic signed [COEF_W-1:0] wr_slope,
    input  logic signed [DATA_W-1:0] wr_offset,
    input  logic                     rd_en,
    input  logic [SEG_W-1:0]         rd_seg,
    input  logic [SHAPE_W-1:0]       rd_shape,
    output logic signed [COEF_W-1:0] slope_q,
    output logic signed [DATA_W-1:0] offset_q
);
    logic signed [COEF_W-1:0] slope_mem  [NUM_SEG][NUM_SHAPE];
    logic signed [DATA_W-1:0] offset_mem [NUM_SEG][NUM_SHAPE];

    // Store a coefficient pair on a write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            slope_mem[wr_seg][wr_shape]  <= wr_slope;
            offset_mem[wr_seg][wr_shape] <= wr_offset;
        end
    end

    // Fetch the pair for the current sample into the stage register.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            slope_q  <= slope_mem[rd_seg][rd_shape];
            offset_q <= offset_mem[rd_seg][rd_shape];
        end
    end

endmodule

// File: rtl/pwl_mac_sat.sv
// Multiply-add stage: forms slope*x + offset, floors to 6 fraction bits,
// clamps to the output range and registers the result.
// Assumes x, slope and offset share FRAC_W fraction bits.
module pwl_mac_sat #(
    parameter int DATA_W = 15,
    parameter int COEF_W = 15,
    parameter int FRAC_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_in,
    input  logic signed [DATA_W-1:0] x,
    input  logic signed [COEF_W-1:0] slope,
    input  logic signed [DATA_W-1:0] offset,
    output logic                     v_out,
    output logic signed [DATA_W-1:0] y
);
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam logic signed [SUM_W-1:0] Y_MAX = SUM_W'((longint'(1) << (DATA_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] Y_MIN = -(SUM_W'(longint'(1) << (DATA_W-1)));

    logic signed [PROD_W-1:0] prod;
    logic signed [SUM_W-1:0]  sum;
    logic signed [SUM_W-1:0]  scaled;
    logic signed [DATA_W-1:0] clamped;

    // Single multiplier and adder, offset aligned to the product's fraction.
    always_comb begin
        prod   = x * slope;
        sum    = SUM_W'(prod) + (SUM_W'(offset) <<< FRAC_W);
        scaled = sum >>> FRAC_W;
    end

    // Clamp to the output rails instead of wrapping.
    always_comb begin
        if (scaled > Y_MAX)
            clamped = Y_MAX[DATA_W-1:0];
        else if (scaled < Y_MIN)
            clamped = Y_MIN[DATA_W-1:0];
        else
            clamped = scaled[DATA_W-1:0];
    end

    // Output register: updates only on a valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_out <= 1'b0;
            y     <= '0;
        end else begin
            v_out <= v_in;
            if (v_in)
                y <= clamped;
        end
    end

    // R7: result held while no valid sample arrives.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !v_in |=> $stable(y));

    // R5: a nonnegative exact sum never comes out negative.
    a_r5_no_wrap_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && !sum[SUM_W-1]) |=> !y[DATA_W-1]);

    // R5: a negative exact sum never comes out nonnegative.
    a_r5_no_wrap_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && sum[SUM_W-1]) |=> y[DATA_W-1]);

endmodule

// File: rtl/pwl_curve_eval.sv
// Top: piecewise-linear curve evaluator. Stage 1 finds the segment and
// fetches the coefficient pair; stage 2 does the multiply-add and clamp.
// Assumes the coefficient store is loaded before samples are sent.
module pwl_curve_eval #(
    parameter int  NUM_SEG   = 16,
    parameter int  NUM_SHAPE = 4,
    parameter int  INT_W     = 8,
    parameter int  FRAC_W    = 6,
    parameter int  COEF_W    = 1 + INT_W + FRAC_W,
    parameter bit  EXP_LAW   = 1'b0,
    localparam int DATA_W    = 1 + INT_W + FRAC_W,
    localparam int SEG_W     = (NUM_SEG > 1)   ? $clog2(NUM_SEG)   : 1,
    localparam int SHAPE_W   = (NUM_SHAPE > 1) ? $clog2(NUM_SHAPE) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] smp_data,
    input  logic [SHAPE_W-1:0]       smp_shape,
    input  logic                     cfg_we,
    input  logic [SEG_W-1:0]         cfg_seg,
    input  logic [SHAPE_W-1:0]       cfg_shape,
    input  logic signed [COEF_W-1:0] cfg_slope,
    input  logic signed [DATA_W-1:0] cfg_offset,
    output logic                     res_valid,
    output logic signed [DATA_W-1:0] res_sample
);
    logic [NUM_SEG-1:0]       ge;
    logic [SEG_W-1:0]         seg;
    logic                     s1_valid;
    logic signed [DATA_W-1:0] s1_x;
    logic signed [COEF_W-1:0] s1_slope;
    logic signed [DATA_W-1:0] s1_offset;

    pwl_seg_finder #(
        .NUM_SEG (NUM_SEG),
        .INT_W   (INT_W),
        .FRAC_W  (FRAC_W),
        .EXP_LAW (EXP_LAW)
    ) u_find (
        .x   (smp_data),
        .ge  (ge),
        .seg (seg)
    );

    pwl_coef_table #(
        .NUM_SEG   (NUM_SEG),
        .NUM_SHAPE (NUM_SHAPE),
        .DATA_W    (DATA_W),
        .COEF_W    (COEF_W)
    ) u_table (
        .clk       (clk),
        .we        (cfg_we),
        .wr_seg    (cfg_seg),
        .wr_shape  (cfg_shape),
        .wr_slope  (cfg_slope),
        .wr_offset (cfg_offset),
        .rd_en     (smp_valid),
        .rd_seg    (seg),
        .rd_shape  (smp_shape),
        .slope_q   (s1_slope),
        .offset_q  (s1_offset)
    );

    // Stage-1 register: carry the sample and its qualifier beside the fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_x     <= '0;
        end else begin
            s1_valid <= smp_valid;
            if (smp_valid)
                s1_x <= smp_data;
        end
    end

    pwl_mac_sat #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .FRAC_W (FRAC_W)
    ) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .v_in   (s1_valid),
        .x      (s1_x),
        .slope  (s1_slope),
        .offset (s1_offset),
        .v_out  (res_valid),
        .y      (res_sample)
    );

    // R2: compare results form a thermometer (boundary k+1 passed implies k passed).
    a_r2_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> (((ge >> 1) & ~ge) == '0));

    // R6: a valid sample yields a valid result two edges later.
    a_r6_latency_on: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> ##2 res_valid);

    // R6: no sample, no result two edges later.
    a_r6_latency_off: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> ##2 !res_valid);

endmodule

// File: tb/pwl_curve_eval_tb.sv
module pwl_curve_eval_tb;
    localparam int NSEG   = 16;
    localparam int NSH    = 4;
    localparam int INT_W  = 8;
    localparam int DW     = 15;
    localparam longint YMAX = 16383;
    localparam longint YMIN = -16384;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [DW-1:0] smp_data = '0;
    logic [1:0] smp_shape = '0;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_seg = '0;
    logic [1:0] cfg_shape = '0;
    logic signed [DW-1:0] cfg_slope = '0;
    logic signed [DW-1:0] cfg_offset = '0;
    logic res_valid;
    logic signed [DW-1:0] res_sample;

    always #10 clk = ~clk;

    pwl_curve_eval u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_shape(smp_shape), .cfg_we(cfg_we), .cfg_seg(cfg_seg),
        .cfg_shape(cfg_shape), .cfg_slope(cfg_slope), .cfg_offset(cfg_offset),
        .res_valid(res_valid), .res_sample(res_sample)
    );

    int n_tests = 0;
    int n_fail  = 0;
    longint slope_m [NSEG][NSH];
    longint off_m   [NSEG][NSH];
    bit     ev1 = 0, ev2 = 0;
    longint ed1 = 0, ed2 = 0;
    string  et1 = "", et2 = "";
    longint last_out = 0;
    bit     done = 0;

    // R1: cubic boundary law in quarter units.
    function automatic longint edge_q(input int k);
        return (longint'(1024) * k * k * k) / (longint'(NSEG) * NSEG * NSEG);
    endfunction

    // R2: segment = boundaries at or below x, minus one, floor 0.
    function automatic int seg_of(input longint x);
        int c = 0;
        for (int k = 0; k < NSEG; k++)
            if (x >= edge_q(k) * 16) c++;
        return (c == 0) ? 0 : c - 1;
    endfunction

    // R4/R5: floor multiply-add with clamp.
    function automatic longint model(input longint x, input int sh);
        int s = seg_of(x);
        longint r = (slope_m[s][sh] * x + off_m[s][sh] * 64) >>> 6;
        if (r > YMAX) r = YMAX;
        if (r < YMIN) r = YMIN;
        return r;
    endfunction

    task automatic check(input string tag, input bit ok, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: check the result due now, then drive the next sample.
    task automatic tick(input bit v, input longint x, input int sh, input string tag);
        @(negedge clk);
        check("R6 valid", res_valid == ev2, longint'(res_valid), longint'(ev2));
        if (ev2) begin
            check(et2, longint'(res_sample) == ed2, longint'(res_sample), ed2);
            last_out = ed2;
        end else begin
            check("R7 hold", longint'(res_sample) == last_out, longint'(res_sample), last_out);
        end
        ev2 = ev1; ed2 = ed1; et2 = et1;
        ev1 = v;   ed1 = v ? model(x, sh) : 0; et1 = tag;
        cfg_we    = 1'b0;
        smp_valid = v;
        smp_data  = DW'(x);
        smp_shape = 2'(sh);
    endtask

    // R3: coefficient write with no sample in flight.
    task automatic wr(input int s, input int sh, input longint sl, input longint of);
        @(negedge clk);
        smp_valid  = 1'b0;
        cfg_we     = 1'b1;
        cfg_seg    = 4'(s);
        cfg_shape  = 2'(sh);
        cfg_slope  = DW'(sl);
        cfg_offset = DW'(of);
        slope_m[s][sh] = sl;
        off_m[s][sh]   = of;
    endtask

    task automatic drain();
        repeat (3) tick(0, 0, 0, "idle");
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R8 reset valid", res_valid == 1'b0, longint'(res_valid), 0);
        check("R8 reset data", res_sample == '0, longint'(res_sample), 0);
        rst_n = 1'b1;

        // Load a random table of moderate slopes (R3).
        for (int s = 0; s < NSEG; s++)
            for (int h = 0; h < NSH; h++)
                wr(s, h, longint'($urandom_range(256)) - 128,
                         longint'($urandom_range(16383)) - 8192);
        drain();

        // Random stream, back to back (R4, R9).
        for (int i = 0; i < 400; i++) begin
            longint x = longint'($signed(15'($urandom)));
            tick(1, x, int'($urandom_range(3)), "R4 random");
        end
        drain();

        // Same sample across all shapes (R9).
        for (int h = 0; h < NSH; h++) tick(1, 1000, h, "R9 shape");

        // Exact boundaries and one step below (R1, R2).
        for (int k = 1; k < NSEG; k++) begin
            if (edge_q(k) != edge_q(k-1)) begin
                tick(1, edge_q(k) * 16, k % NSH, "R1 at edge");
                tick(1, edge_q(k) * 16 - 1, k % NSH, "R2 below edge");
            end
        end
        tick(1, YMAX, 0, "R2 top segment");
        tick(1, YMIN, 1, "R2 bottom segment");
        tick(1, -1, 2, "R2 negative");
        drain();

        // Idle gap with stray sample values (R7).
        for (int i = 0; i < 5; i++) tick(0, longint'($urandom_range(9999)), 0, "idle");

        // Saturation and floor rounding (R5, R4), with overwritten entries (R3).
        wr(NSEG-1, 0, 16383, 16383);
        wr(NSEG-1, 1, -16384, -16384);
        wr(1, 2, -1, 0);
        drain();
        tick(1, YMAX, 0, "R5 high rail");
        tick(1, YMAX, 1, "R5 low rail");
        tick(1, 1, 2, "R4 floor negative");
        tick(1, 20, 2, "R3 overwrite used");
        drain();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule